// File: doc/BRIEF.md
# Periodic Aging Counter Unit

This block tracks how recently each of N resident entries has been used, as an approximation of least-recently-used order. An access marks its entry with a sticky reference flag. The ages are refreshed only once per sampling interval, so the update rate does not depend on how often entries are accessed. A cycle-count interval timer starts each refresh.

A refresh, called a sweep, visits one entry per clock. The entry's 8-bit age moves one place toward the least significant bit, its reference flag enters at the top, and the flag is then cleared. Any agent can ask for a victim. One cycle later the unit returns the index of the entry with the smallest age, together with that age.

Top module: `aging_lru`

## Requirements
- R1: After reset all ages and reference flags are zero, `sweep_busy` and `vic_valid` are low, and a victim query returns index 0 with age 0.
- R2: With `period` = P and P nonzero, a sweep starts P cycles after the timer was last restarted. `period` = 0 stops the timer and clears its count. Once a sweep starts, `sweep_busy` stays high for exactly N cycles.
- R3: When a sweep visits an entry, the new age is the old age shifted right by one, with bit 7 (0x80) set if and only if the entry was referenced. From zero, the reference pattern yes, yes, yes, no, no, no gives ages 128, 192, 224, 112, 56, 28.
- R4: Any access sets the entry's reference flag. The sweep clears the flag in the same cycle that it samples it, so an unreferenced interval halves the age.
- R5: The sweep visits entries in ascending index order, one per cycle. During a sweep, an access to an entry that has already been visited counts toward the next interval. An access to an entry not yet visited, or to the entry being visited in that cycle, counts in the current sweep.
- R6: A timer tick that arrives during a sweep is held pending. The next sweep then starts on the cycle right after `sweep_busy` falls.
- R7: `vic_valid` is high exactly in the cycle after `vic_req`. In that cycle `vic_idx` and `vic_age` name the entry with the minimum age, and the lowest index wins a tie. If every age is 0xFF, the result is index 0 with age 0xFF.
- R8: Ages change only during a sweep. Accesses between sweeps do not alter any age.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access occurs this cycle |
| acc_idx | input | IDX_W | Entry touched by the access |
| period | input | PER_W | Sampling interval in cycles; 0 disables the timer |
| vic_req | input | 1 | Victim query |
| vic_idx | output | IDX_W | Entry with the smallest age |
| vic_age | output | AGE_W | Age of that entry |
| vic_valid | output | 1 | Victim result valid, one cycle after the query |
| sweep_busy | output | 1 | A sweep is in progress |

## Verification
The assertions assume that `acc_idx` is below N whenever `acc_valid` is high. They also assume that `vic_req` is a plain one-cycle level with no handshake behind it. The stimulus only ever drives indices 0 to 7 on the default eight-entry build. It changes `period` only at chosen moments: it raises `period` to start one sweep and drops it to zero as soon as `sweep_busy` is seen. This keeps the number of sweeps exactly known, except in the pending-tick test, which uses a short interval on purpose.

// File: rtl/aging_lru.sv
module aging_lru #(
  parameter int N     = 8,
  parameter int AGE_W = 8,
  parameter int PER_W = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic [PER_W-1:0] period,
  input  logic             vic_req,
  output logic [IDX_W-1:0] vic_idx,
  output logic [AGE_W-1:0] vic_age,
  output logic             vic_valid,
  output logic             sweep_busy
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [N-1:0][AGE_W-1:0] age_q;
  logic [N-1:0]            ref_q, ref_d;
  logic [PER_W-1:0]        tmr_q;
  logic [IDX_W-1:0]        ptr_q;
  logic                    busy_q, pend_q;
  logic                    tick, start, samp;
  logic [AGE_W-1:0]        best_age;
  logic [IDX_W-1:0]        best_idx;

  assign tick  = (period != '0) && (tmr_q >= period - PER_W'(1));
  assign start = !busy_q && (tick || pend_q);
  assign samp  = ref_q[ptr_q] | (acc_valid && acc_idx == ptr_q);
  assign sweep_busy = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                          tmr_q <= '0;
    else if (period == '0 || tick)       tmr_q <= '0;
    else                                 tmr_q <= tmr_q + PER_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 pend_q <= 1'b0;
    else if (busy_q && tick)    pend_q <= 1'b1;
    else if (start)             pend_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      ptr_q  <= '0;
    end else if (busy_q) begin
      busy_q <= (ptr_q != LAST);
      ptr_q  <= (ptr_q == LAST) ? '0 : ptr_q + IDX_W'(1);
    end
  end

  always_comb begin
    ref_d = ref_q;
    if (acc_valid) ref_d[acc_idx] = 1'b1;
    if (busy_q)    ref_d[ptr_q]   = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ref_q <= '0;
    else        ref_q <= ref_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      age_q <= '0;
    else if (busy_q) age_q[ptr_q] <= {samp, age_q[ptr_q][AGE_W-1:1]};
  end

  always_comb begin
    best_age = '1;
    best_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (age_q[i] < best_age) begin
        best_age = age_q[i];
        best_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vic_valid <= 1'b0;
      vic_idx   <= '0;
      vic_age   <= '0;
    end else begin
      vic_valid <= vic_req;
      if (vic_req) begin
        vic_idx <= best_idx;
        vic_age <= best_age;
      end
    end
  end

  // R8: ages hold outside a sweep
  a_r8_age_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sweep_busy |=> $stable(age_q));

  // R3: the visited entry keeps its upper bits shifted down
  a_r3_shift: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_busy |=> age_q[$past(ptr_q)][AGE_W-2:0] == $past(age_q[ptr_q][AGE_W-1:1]));

  // R4: the visited entry's flag is cleared
  a_r4_ref_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_busy |=> !ref_q[$past(ptr_q)]);

  // R7: result valid exactly one cycle after the query
  a_r7_valid_hi: assert property (@(posedge clk) disable iff (!rst_n)
    vic_req |=> vic_valid);
  a_r7_valid_lo: assert property (@(posedge clk) disable iff (!rst_n)
    !vic_req |=> !vic_valid);

  // R2: a sweep always finishes on the last entry
  a_r2_sweep_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sweep_busy) |-> $past(ptr_q) == LAST);

  // R7: the reported age never exceeds any entry's age
  for (genvar g = 0; g < N; g++) begin : g_min_chk
    a_r7_min: assert property (@(posedge clk) disable iff (!rst_n)
      vic_req |=> vic_age <= $past(age_q[g]));
  end

endmodule

// File: tb/test_aging_lru.sv
module test_aging_lru;
  localparam int N = 8;
  localparam int PER = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [2:0]  acc_idx = '0;
  logic [15:0] period = '0;
  logic        vic_req = 1'b0;
  logic [2:0]  vic_idx;
  logic [7:0]  vic_age;
  logic        vic_valid, sweep_busy;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  aging_lru #(.N(N), .AGE_W(8), .PER_W(16)) i_aging_lru (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_idx(acc_idx),
    .period(period), .vic_req(vic_req), .vic_idx(vic_idx), .vic_age(vic_age),
    .vic_valid(vic_valid), .sweep_busy(sweep_busy));

  // {access mask, expected victim index, expected victim age}
  localparam logic [23:0] VEC [0:8] = '{
    24'hFF_00_80, 24'hFF_00_C0, 24'hFF_00_E0,
    24'hFE_00_70, 24'hFE_00_38, 24'hFE_00_1C,
    24'h01_01_7E, 24'h03_02_3F, 24'hFC_01_5F };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    period = '0;
    acc_valid = 1'b0;
    vic_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic touch(input logic [7:0] mask);
    for (int i = 0; i < N; i++) begin
      if (mask[i]) begin
        acc_valid = 1'b1;
        acc_idx = 3'(i);
        @(negedge clk);
        acc_valid = 1'b0;
      end
    end
  endtask

  task automatic sweep(input int k1, input int i1, input int k2, input int i2,
                       output int rise, output int blen);
    int k;
    period = 16'(PER);
    rise = 0;
    do begin
      @(negedge clk);
      rise++;
    end while (!sweep_busy && rise < 1000);
    period = '0;
    blen = 0;
    k = 0;
    while (sweep_busy && blen < 1000) begin
      acc_valid = (k == k1) || (k == k2);
      acc_idx = (k == k1) ? 3'(i1) : 3'(i2);
      @(negedge clk);
      acc_valid = 1'b0;
      blen++;
      k++;
    end
  endtask

  task automatic query(input string req, input int eidx, input int eage);
    vic_req = 1'b1;
    @(negedge clk);
    vic_req = 1'b0;
    chk(vic_valid === 1'b1, req, "vic_valid after query", int'(vic_valid), 1);
    chk(vic_idx === 3'(eidx), req, "vic_idx", int'(vic_idx), eidx);
    chk(vic_age === 8'(eage), req, "vic_age", int'(vic_age), eage);
    @(negedge clk);
    chk(vic_valid === 1'b0, req, "vic_valid without query", int'(vic_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int rise, blen;
    do_reset();
    // R1: reset state
    chk(sweep_busy === 1'b0, "R1", "sweep_busy after reset", int'(sweep_busy), 0);
    chk(vic_valid === 1'b0, "R1", "vic_valid after reset", int'(vic_valid), 0);
    query("R1", 0, 0);

    // R8: accesses between sweeps leave ages alone
    touch(8'hFF);
    repeat (5) @(negedge clk);
    query("R8", 0, 0);

    // R2: timer disabled with period 0
    period = '0;
    blen = 0;
    repeat (40) begin
      @(negedge clk);
      if (sweep_busy) blen++;
    end
    chk(blen == 0, "R2", "busy cycles with timer off", blen, 0);

    // R3, R4, R7: vector table (flags from the earlier touch are cleared first)
    do_reset();
    for (int r = 0; r < 9; r++) begin
      touch(VEC[r][23:16]);
      sweep(-1, 0, -1, 0, rise, blen);
      if (r == 0) begin
        chk(rise == PER, "R2", "cycles to sweep start", rise, PER);
        chk(blen == N, "R2", "sweep length", blen, N);
      end
      query((r < 6) ? "R3" : "R7", int'(VEC[r][15:8]), int'(VEC[r][7:0]));
    end

    // R7: all ages saturated
    do_reset();
    for (int s = 0; s < 8; s++) begin
      touch(8'hFF);
      sweep(-1, 0, -1, 0, rise, blen);
    end
    query("R7", 0, 255);

    // R5, R4: accesses during a sweep
    do_reset();
    touch(8'hFF);
    sweep(-1, 0, -1, 0, rise, blen);
    sweep(3, 1, 4, 6, rise, blen);
    touch(8'hBD);
    sweep(-1, 0, -1, 0, rise, blen);
    query("R5", 6, 96);

    // R6: a tick during a sweep is held pending
    do_reset();
    period = 16'd5;
    rise = 0;
    do begin
      @(negedge clk);
      rise++;
    end while (!sweep_busy && rise < 100);
    while (sweep_busy && rise < 200) begin
      @(negedge clk);
      rise++;
    end
    @(negedge clk);
    chk(sweep_busy === 1'b1, "R6", "restart after pending tick", int'(sweep_busy), 1);
    period = '0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule